// File: doc/BRIEF.md
# HDLC Receive Deframer and Frame Checker

This block sits behind a bit-serial line receiver and turns a raw HDLC bit stream into checked frames. It hunts for the 01111110 flag to gain frame synchronisation, strips the zero that a transmitter inserts after five consecutive ones, and packs the surviving bits into bytes, least significant bit first. Every data bit is also fed through a bit-serial CRC-16 (generator x^16 + x^12 + x^5 + 1), so the closing flag can be judged at once.

At each closing flag the block publishes the first byte of the frame (address), the second byte (control), the frame kind decoded from the control byte, the send and receive sequence numbers, and a good/bad verdict. The information bytes between the control byte and the two FCS bytes leave on a byte stream with start and end markers. The FCS bytes themselves never appear there. Bits arrive one per cycle when `bit_valid` is high. There is no back-pressure.

Control is a two-state machine. ST_HUNT ignores data and waits for a flag. The *sync* transition leads from ST_HUNT to ST_FRAME on a flag. In ST_FRAME, the *close* transition (ST_FRAME to ST_FRAME on a flag) reports any frame that held data, and the same flag opens the next frame. The *abort* transition (ST_FRAME to ST_HUNT on a seventh consecutive one) drops the frame in progress.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset `frm_done`, `frm_good` and `info_valid` are low.
- R2: While no flag has been seen since reset or since an abort, incoming bits produce no frame report and no information byte.
- R3: A 0 that follows five consecutive 1 bits inside a frame is removed before byte assembly. Bytes are assembled least significant bit first.
- R4: A frame is reported good (`frm_done` and `frm_good` high for one cycle) when all of the following hold:
  - it has at least four bytes (address, control, two FCS bytes);
  - it ends on a byte boundary;
  - the CRC-16 (preset 0xFFFF, complemented FCS sent low byte first) run over all of its bits leaves the residue 0xF0B8.
  At that report, `frm_addr` and `frm_ctrl` carry bytes 0 and 1.
- R5: A frame whose FCS does not match its contents is reported with `frm_done` high and `frm_good` low.
- R6: `frm_kind` is 0 (I frame) when control bit 0 is 0, 1 (S frame) when bits 1:0 are 01, and 2 (U frame) when bits 1:0 are 11.
- R7: For an I frame, `frm_ns` = control bits 3:1 and `frm_nr` = control bits 7:5. For an S frame, `frm_nr` = bits 7:5 and `frm_ns` = 0. For a U frame, both are 0.
- R8: Information bytes (bytes 2 to n-3 of an n-byte frame) leave in order on `info_byte` with `info_valid`:
  - the first of them carries `info_first`;
  - the last of them carries `info_last`, in the same cycle as `frm_done`;
  - a frame of four bytes emits none.
- R9: A frame with data bits but fewer than four bytes is reported bad. Two flags with no data between them produce no report.
- R10: A frame whose data bit count is not a multiple of eight is reported bad, even when its CRC residue is correct.
- R11: Seven consecutive 1 bits inside a frame abort it: a bad report is given if it held data, and the block returns to hunting. Runs of ones outside a frame produce no report.
- R12: Cycles with `bit_valid` low have no effect, whatever `bit_in` carries.
- R13: A single flag closes one frame and opens the next (shared flag).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| frm_done | output | 1 | One-cycle frame report pulse |
| frm_good | output | 1 | Report verdict, high only with `frm_done` |
| frm_addr | output | 8 | Address byte of the reported frame |
| frm_ctrl | output | 8 | Control byte of the reported frame |
| frm_kind | output | 2 | 0 = I, 1 = S, 2 = U |
| frm_ns | output | 3 | Send sequence number |
| frm_nr | output | 3 | Receive sequence number |
| info_valid | output | 1 | `info_byte` holds an information byte |
| info_byte | output | 8 | Information byte |
| info_first | output | 1 | First information byte of a frame |
| info_last | output | 1 | Last information byte of a frame |

## Verification
Two situations are hard to reach from the ports:
- A frame whose CRC residue is right but whose length is not whole bytes. The bench transmitter works at bit level and keeps its own CRC, so it can append three loose bits and still send a matching FCS. This isolates the alignment rule from the CRC rule.
- An abort partway through a frame, followed by data that must be ignored while hunting. The bench drives raw unstuffed ones to make the abort, then sends byte patterns that contain no flag before opening a fresh frame.

Stuffing at byte and FCS boundaries is exercised with 0xFF and 0x7E payloads. Gapped `bit_valid` with `bit_in` held at 1 on idle cycles shows that idle cycles cannot build a false flag or abort.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEQ_W      = 3;
    localparam int CRC_W      = 16;
    localparam int STUFF_ONES = 5;
    localparam int FLAG_ONES  = 6;
    localparam int TAIL_BITS  = FLAG_ONES + 1;   // leading 0 plus six 1s of a flag
    localparam int MIN_BYTES  = 4;               // address, control, FCS x2
    localparam int INFO_LAG   = 3;               // bytes held back before emission

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_RESIDUE   = 16'hF0B8;

    typedef enum logic [1:0] {
        KIND_I = 2'd0,
        KIND_S = 2'd1,
        KIND_U = 2'd2
    } frame_kind_e;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

endpackage

// File: rtl/hdlc_bit_destuff.sv
module hdlc_bit_destuff
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit,
    output logic flag_hit,
    output logic abort_hit
);
    localparam int RUN_MAX = FLAG_ONES + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_ONES);
    localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(FLAG_ONES);
    localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(RUN_MAX);

    logic [RUN_W-1:0] ones_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (in_valid) begin
            if (!in_bit)
                ones_q <= '0;
            else if (ones_q != RUN_SAT)
                ones_q <= ones_q + 1'b1;
        end
    end

    assign out_bit = in_bit;

    always_comb begin
        out_valid = 1'b0;
        flag_hit  = 1'b0;
        abort_hit = 1'b0;
        if (in_valid) begin
            if (in_bit) begin
                if (ones_q == RUN_FLAG)
                    abort_hit = 1'b1;
                else if (ones_q < RUN_FLAG)
                    out_valid = 1'b1;
            end else begin
                if (ones_q == RUN_FLAG)
                    flag_hit = 1'b1;
                else if (ones_q < RUN_STUFF)
                    out_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
    parameter int               W     = 16,
    parameter logic [W-1:0]     POLY  = 16'h8408,
    parameter logic [W-1:0]     INIT  = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = crc[0] ^ din;
        nxt = crc >> 1;
        if (fb)
            nxt = nxt ^ POLY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= INIT;
        else if (clear)
            crc <= INIT;
        else if (en)
            crc <= nxt;
    end

endmodule

// File: rtl/hdlc_ctrl_decode.sv
module hdlc_ctrl_decode
    import hdlc_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] ctrl,
    output frame_kind_e       kind,
    output logic [SEQ_W-1:0]  ns,
    output logic [SEQ_W-1:0]  nr
);
    always_comb begin
        kind = KIND_U;
        ns   = '0;
        nr   = '0;
        if (!ctrl[0]) begin
            kind = KIND_I;
            ns   = ctrl[SEQ_W:1];
            nr   = ctrl[BYTE_W-1 -: SEQ_W];
        end else if (!ctrl[1]) begin
            kind = KIND_S;
            nr   = ctrl[BYTE_W-1 -: SEQ_W];
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              frm_done,
    output logic              frm_good,
    output logic [7:0]        frm_addr,
    output logic [7:0]        frm_ctrl,
    output logic [1:0]        frm_kind,
    output logic [2:0]        frm_ns,
    output logic [2:0]        frm_nr,
    output logic              info_valid,
    output logic [7:0]        info_byte,
    output logic              info_first,
    output logic              info_last
);
    localparam int FILL_W = $clog2(TAIL_BITS + 1);
    localparam int BCNT_W = $clog2(BYTE_W);
    localparam int NB_MAX = MIN_BYTES + INFO_LAG;
    localparam int NB_W   = $clog2(NB_MAX + 1);

    localparam logic [FILL_W-1:0] FILL_FULL  = FILL_W'(TAIL_BITS);
    localparam logic [BCNT_W-1:0] BCNT_LAST  = BCNT_W'(BYTE_W - 1);
    localparam logic [NB_W-1:0]   NB_SAT     = NB_W'(NB_MAX);
    localparam logic [NB_W-1:0]   NB_MIN     = NB_W'(MIN_BYTES);
    localparam logic [NB_W-1:0]   NB_EMIT    = NB_W'(MIN_BYTES + 1);
    localparam logic [NB_W-1:0]   NB_ADDR    = NB_W'(0);
    localparam logic [NB_W-1:0]   NB_CTRL    = NB_W'(1);

    // ---------------- bit level ----------------
    logic d_valid, d_bit, flag_hit, abort_hit;

    hdlc_bit_destuff u_destuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (bit_valid),
        .in_bit    (bit_in),
        .out_valid (d_valid),
        .out_bit   (d_bit),
        .flag_hit  (flag_hit),
        .abort_hit (abort_hit)
    );

    // ---------------- state machine ----------------
    rx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (flag_hit)  state_d = ST_FRAME;   // sync
            ST_FRAME: if (abort_hit) state_d = ST_HUNT;    // abort; flag = close
            default:  state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    // ---------------- datapath ----------------
    logic [TAIL_BITS-1:0] tail_q;
    logic [FILL_W-1:0]    fill_q;
    logic [BYTE_W-1:0]    sr_q;
    logic [BCNT_W-1:0]    bcnt_q;
    logic [NB_W-1:0]      nbytes_q;
    logic [BYTE_W-1:0]    lag_q [INFO_LAG];
    logic [BYTE_W-1:0]    addr_w, ctrl_w;

    logic              in_frame, restart, pop_en, pop_bit, byte_done, has_data;
    logic [BYTE_W-1:0] new_byte;

    assign in_frame  = (state_q == ST_FRAME);
    assign restart   = !in_frame || flag_hit || abort_hit;
    assign pop_en    = in_frame && d_valid && (fill_q == FILL_FULL);
    assign pop_bit   = tail_q[0];
    assign byte_done = pop_en && (bcnt_q == BCNT_LAST);
    assign new_byte  = {pop_bit, sr_q[BYTE_W-1:1]};
    assign has_data  = (nbytes_q != '0) || (bcnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tail_q   <= '0;
            fill_q   <= '0;
            sr_q     <= '0;
            bcnt_q   <= '0;
            nbytes_q <= '0;
        end else if (d_valid) begin
            tail_q <= {d_bit, tail_q[TAIL_BITS-1:1]};
            if (fill_q != FILL_FULL)
                fill_q <= fill_q + 1'b1;
            if (pop_en) begin
                sr_q   <= new_byte;
                bcnt_q <= bcnt_q + 1'b1;
            end
            if (byte_done && nbytes_q != NB_SAT)
                nbytes_q <= nbytes_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_w <= '0;
            ctrl_w <= '0;
        end else if (byte_done) begin
            if (nbytes_q == NB_ADDR) addr_w <= new_byte;
            if (nbytes_q == NB_CTRL) ctrl_w <= new_byte;
        end
    end

    for (genvar g = 0; g < INFO_LAG; g++) begin : g_lag
        always_ff @(posedge clk) begin
            if (!rst_n)
                lag_q[g] <= '0;
            else if (byte_done)
                lag_q[g] <= (g == 0) ? new_byte : lag_q[(g == 0) ? 0 : g-1];
        end
    end

    // ---------------- checks and decode ----------------
    logic [CRC_W-1:0] crc;

    hdlc_crc16 #(
        .W    (CRC_W),
        .POLY (CRC_POLY_REFL),
        .INIT (CRC_PRESET)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .en    (pop_en),
        .din   (pop_bit),
        .crc   (crc)
    );

    frame_kind_e      dec_kind;
    logic [SEQ_W-1:0] dec_ns, dec_nr;

    hdlc_ctrl_decode u_dec (
        .ctrl (ctrl_w),
        .kind (dec_kind),
        .ns   (dec_ns),
        .nr   (dec_nr)
    );

    logic close_rep, abort_rep, frame_ok;

    assign close_rep = in_frame && flag_hit && has_data;
    assign abort_rep = in_frame && abort_hit && has_data;
    assign frame_ok  = (bcnt_q == '0) && (nbytes_q >= NB_MIN) && (crc == CRC_RESIDUE);

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_done   <= 1'b0;
            frm_good   <= 1'b0;
            frm_addr   <= '0;
            frm_ctrl   <= '0;
            frm_kind   <= '0;
            frm_ns     <= '0;
            frm_nr     <= '0;
            info_valid <= 1'b0;
            info_byte  <= '0;
            info_first <= 1'b0;
            info_last  <= 1'b0;
        end else begin
            frm_done   <= 1'b0;
            frm_good   <= 1'b0;
            info_valid <= 1'b0;
            info_first <= 1'b0;
            info_last  <= 1'b0;
            if (close_rep || abort_rep) begin
                frm_done <= 1'b1;
                frm_good <= close_rep && frame_ok;
                frm_addr <= addr_w;
                frm_ctrl <= ctrl_w;
                frm_kind <= dec_kind;
                frm_ns   <= dec_ns;
                frm_nr   <= dec_nr;
            end
            if (close_rep && nbytes_q >= NB_EMIT) begin
                info_valid <= 1'b1;
                info_byte  <= lag_q[INFO_LAG-1];
                info_first <= (nbytes_q == NB_EMIT);
                info_last  <= 1'b1;
            end else if (byte_done && nbytes_q >= NB_EMIT) begin
                info_valid <= 1'b1;
                info_byte  <= lag_q[INFO_LAG-1];
                info_first <= (nbytes_q == NB_EMIT);
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       bit_in,
    input logic       frm_done,
    input logic       frm_good,
    input logic [7:0] frm_ctrl,
    input logic [1:0] frm_kind,
    input logic [2:0] frm_ns,
    input logic [2:0] frm_nr,
    input logic       info_valid,
    input logic       info_first,
    input logic       info_last
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (bit_valid)
            run_q <= !bit_in ? 3'd0 : (run_q == 3'd7 ? run_q : run_q + 3'd1);
    end

    // R4
    good_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_good |-> frm_done);

    // R6
    kind_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_ctrl[0]) |-> (frm_kind == 2'd0));

    // R6
    kind_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_ctrl[1:0] == 2'b01) |-> (frm_kind == 2'd1));

    // R6
    kind_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_ctrl[1:0] == 2'b11) |-> (frm_kind == 2'd2));

    // R7
    u_seq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_kind == 2'd2) |-> (frm_ns == 3'd0 && frm_nr == 3'd0));

    // R7
    i_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_kind == 2'd0) |-> (frm_ns == frm_ctrl[3:1] && frm_nr == frm_ctrl[7:5]));

    // R8
    last_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_last |-> (frm_done && info_valid));

    // R8
    first_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_first |-> info_valid);

    // R11
    abort_not_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == 3'd6 && bit_valid && bit_in) |=> !frm_good);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_valid) |-> (!frm_done && !info_valid));

endmodule

bind hdlc_rx_deframer hdlc_rx_checker u_chk (.*);

// File: tb/hdlc_rx_deframer_bench.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_valid;
    logic       bit_in;
    logic       frm_done, frm_good, info_valid, info_first, info_last;
    logic [7:0] frm_addr, frm_ctrl, info_byte;
    logic [1:0] frm_kind;
    logic [2:0] frm_ns, frm_nr;

    always #2 clk = ~clk;

    hdlc_rx_deframer u_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .frm_done(frm_done), .frm_good(frm_good), .frm_addr(frm_addr),
        .frm_ctrl(frm_ctrl), .frm_kind(frm_kind), .frm_ns(frm_ns), .frm_nr(frm_nr),
        .info_valid(info_valid), .info_byte(info_byte),
        .info_first(info_first), .info_last(info_last)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // ---------------- monitor ----------------
    int         done_cnt, good_cnt, info_cnt, last_with_done;
    logic       m_good;
    logic [7:0] m_addr, m_ctrl;
    logic [1:0] m_kind;
    logic [2:0] m_ns, m_nr;
    logic [7:0] m_info  [16];
    logic       m_first [16];
    logic       m_last  [16];

    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_done) begin
                done_cnt++;
                if (frm_good) good_cnt++;
                m_good = frm_good;
                m_addr = frm_addr;
                m_ctrl = frm_ctrl;
                m_kind = frm_kind;
                m_ns   = frm_ns;
                m_nr   = frm_nr;
            end
            if (info_valid && info_cnt < 16) begin
                m_info[info_cnt]  = info_byte;
                m_first[info_cnt] = info_first;
                m_last[info_cnt]  = info_last;
                if (info_last && frm_done) last_with_done++;
                info_cnt++;
            end
        end
    end

    task automatic clear_mon();
        done_cnt = 0; good_cnt = 0; info_cnt = 0; last_with_done = 0;
        m_good = 0; m_addr = 0; m_ctrl = 0; m_kind = 0; m_ns = 0; m_nr = 0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- transmitter model ----------------
    logic [15:0] tx_crc;
    int          tx_ones;
    bit          gap_mode = 0;
    logic [7:0]  tx_info [16];

    task automatic raw_bit(input logic b);
        bit_in    = b;
        bit_valid = 1'b1;
        @(negedge clk);
        if (gap_mode) begin
            bit_valid = 1'b0;
            bit_in    = 1'b1;
            @(negedge clk);
        end
        bit_valid = 1'b0;
    endtask

    task automatic data_bit(input logic b);
        logic fb;
        fb     = tx_crc[0] ^ b;
        tx_crc = tx_crc >> 1;
        if (fb) tx_crc = tx_crc ^ 16'h8408;
        raw_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                raw_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic data_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) data_bit(v[i]);
    endtask

    task automatic flag();
        raw_bit(1'b0);
        for (int i = 0; i < 6; i++) raw_bit(1'b1);
        raw_bit(1'b0);
        tx_ones = 0;
        tx_crc  = 16'hFFFF;
    endtask

    task automatic send_fcs(input bit corrupt);
        logic [15:0] f;
        f = ~tx_crc;
        if (corrupt) f = f ^ 16'h0001;
        for (int i = 0; i < 16; i++) data_bit(f[i]);
    endtask

    task automatic send_body(input logic [7:0] a, input logic [7:0] c, input int n, input bit corrupt);
        data_byte(a);
        data_byte(c);
        for (int i = 0; i < n; i++) data_byte(tx_info[i]);
        send_fcs(corrupt);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input int n, input bit corrupt);
        flag();
        send_body(a, c, n, corrupt);
        flag();
        settle();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 frm_done after reset", int'(frm_done), 0);
        chk("R1 frm_good after reset", int'(frm_good), 0);
        chk("R1 info_valid after reset", int'(info_valid), 0);
    endtask

    task automatic t_hunt();
        clear_mon();
        for (int r = 0; r < 4; r++) begin
            raw_bit(1); raw_bit(0); raw_bit(1); raw_bit(1); raw_bit(0);
            raw_bit(0); raw_bit(1); raw_bit(1); raw_bit(0); raw_bit(1);
        end
        settle();
        chk("R2 no report before flag", done_cnt, 0);
        chk("R2 no info before flag", info_cnt, 0);
    endtask

    task automatic t_iframe();
        clear_mon();
        tx_info[0] = 8'h11; tx_info[1] = 8'h7E; tx_info[2] = 8'hFF;
        send_frame(8'h03, 8'h4A, 3, 0);
        chk("R4 I frame reported", done_cnt, 1);
        chk("R4 I frame good", int'(m_good), 1);
        chk("R4 address", int'(m_addr), 'h03);
        chk("R4 control", int'(m_ctrl), 'h4A);
        chk("R6 kind I", int'(m_kind), 0);
        chk("R7 I ns", int'(m_ns), 5);
        chk("R7 I nr", int'(m_nr), 2);
        chk("R8 info count", info_cnt, 3);
        chk("R3 info byte 0", int'(m_info[0]), 'h11);
        chk("R3 info byte 1 stuffed", int'(m_info[1]), 'h7E);
        chk("R3 info byte 2 stuffed", int'(m_info[2]), 'hFF);
        chk("R8 first marker", int'(m_first[0]), 1);
        chk("R8 no first on byte 1", int'(m_first[1]), 0);
        chk("R8 no last on byte 1", int'(m_last[1]), 0);
        chk("R8 last marker", int'(m_last[2]), 1);
        chk("R8 last with report", last_with_done, 1);
    endtask

    task automatic t_sframe();
        clear_mon();
        send_frame(8'hFF, 8'hC1, 0, 0);
        chk("R4 S frame good", int'(m_good), 1);
        chk("R6 kind S", int'(m_kind), 1);
        chk("R7 S nr", int'(m_nr), 6);
        chk("R7 S ns zero", int'(m_ns), 0);
        chk("R8 no info for 4-byte frame", info_cnt, 0);
    endtask

    task automatic t_uframe();
        clear_mon();
        tx_info[0] = 8'h55;
        send_frame(8'h01, 8'h3F, 1, 0);
        chk("R4 U frame good", int'(m_good), 1);
        chk("R6 kind U", int'(m_kind), 2);
        chk("R7 U ns zero", int'(m_ns), 0);
        chk("R7 U nr zero", int'(m_nr), 0);
        chk("R8 single info count", info_cnt, 1);
        chk("R8 single info value", int'(m_info[0]), 'h55);
        chk("R8 single first", int'(m_first[0]), 1);
        chk("R8 single last", int'(m_last[0]), 1);
    endtask

    task automatic t_badfcs();
        clear_mon();
        tx_info[0] = 8'hA0; tx_info[1] = 8'h0B;
        send_frame(8'h03, 8'h10, 2, 1);
        chk("R5 bad FCS reported", done_cnt, 1);
        chk("R5 bad FCS verdict", int'(m_good), 0);
    endtask

    task automatic t_short();
        clear_mon();
        flag();
        data_byte(8'h03); data_byte(8'h00); data_byte(8'h21);
        flag();
        settle();
        chk("R9 short frame reported", done_cnt, 1);
        chk("R9 short frame bad", int'(m_good), 0);
        clear_mon();
        flag(); flag(); flag();
        settle();
        chk("R9 empty flags no report", done_cnt, 0);
    endtask

    task automatic t_misalign();
        clear_mon();
        flag();
        data_byte(8'h03); data_byte(8'h00); data_byte(8'h44);
        data_bit(1'b1); data_bit(1'b0); data_bit(1'b1);
        send_fcs(0);
        flag();
        settle();
        chk("R10 misaligned reported", done_cnt, 1);
        chk("R10 misaligned bad", int'(m_good), 0);
    endtask

    task automatic t_abort();
        clear_mon();
        flag();
        data_byte(8'h05); data_byte(8'h02); data_byte(8'h12); data_byte(8'h34);
        for (int i = 0; i < 7; i++) raw_bit(1'b1);
        settle();
        chk("R11 abort reported", done_cnt, 1);
        chk("R11 abort bad", int'(m_good), 0);
        chk("R11 abort no info", info_cnt, 0);
        data_byte(8'h00); data_byte(8'h0F); data_byte(8'h00); data_byte(8'h0F);
        data_byte(8'h00); data_byte(8'h0F);
        settle();
        chk("R11 hunting after abort", done_cnt, 1);
        tx_info[0] = 8'h99;
        send_frame(8'h07, 8'h02, 1, 0);
        chk("R11 resync good", good_cnt, 1);
        for (int i = 0; i < 12; i++) raw_bit(1'b1);
        settle();
        chk("R11 idle ones no report", done_cnt, 2);
    endtask

    task automatic t_gaps();
        clear_mon();
        gap_mode = 1;
        tx_info[0] = 8'hA5; tx_info[1] = 8'h3C;
        send_frame(8'h0C, 8'h26, 2, 0);
        gap_mode = 0;
        chk("R12 gapped frame good", good_cnt, 1);
        chk("R12 gapped info count", info_cnt, 2);
        chk("R12 gapped info byte", int'(m_info[1]), 'h3C);
        chk("R12 gapped ns", int'(m_ns), 3);
    endtask

    task automatic t_shared();
        clear_mon();
        tx_info[0] = 8'h01;
        flag();
        send_body(8'h10, 8'h00, 1, 0);
        flag();
        send_body(8'h20, 8'h11, 0, 0);
        flag();
        settle();
        chk("R13 two reports", done_cnt, 2);
        chk("R13 both good", good_cnt, 2);
        chk("R13 second address", int'(m_addr), 'h20);
    endtask

    // ---------------- run ----------------
    initial begin
        rst_n     = 1'b0;
        bit_valid = 1'b0;
        bit_in    = 1'b1;
        tx_ones   = 0;
        tx_crc    = 16'hFFFF;
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hunt();
        t_iframe();
        t_sframe();
        t_uframe();
        t_badfcs();
        t_short();
        t_misalign();
        t_abort();
        t_gaps();
        t_shared();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule